// File: doc/BRIEF.md
# Transaction Fragmenter with Per-Fragment Acceptance

This block sits between a traffic source and an ingress queue. It takes one transaction descriptor at a time: a byte count, a source ID, a destination ID and a tag. It cuts the transaction into fragments, each no larger than a configurable maximum payload. Every fragment is offered to the queue with a valid/accept handshake. The next fragment is not built until the current one has been taken. After each acceptance the block stays idle for one cycle. It then spends a generation delay on the next fragment. That delay is the fragment size divided by the interface rate, rounded up to whole cycles.

Each fragment descriptor carries its byte count, first and last markers, and copies of the source ID, destination ID and tag. With source flow control enabled, the block refuses new work while it is busy. It raises a one-cycle completion event once the last fragment has been accepted, which tells the source it may pop its next transaction. With source flow control disabled, a one-entry staging register takes a new transaction while the current one is still being cut, and no completion event is raised.

Top module: `txn_fragmenter`

## Requirements
- R1: After reset, `frag_valid` and `txn_done` are 0 and `txn_ready` is 1.
- R2: Every fragment except the last carries exactly MAX_PAYLOAD bytes (default 256). The last carries the remainder, so the fragment sizes add up to the transaction byte count.
- R3: `frag_first` is 1 only on a transaction's first fragment and `frag_last` only on its final one. A transaction of exactly MAX_PAYLOAD bytes yields one fragment with both markers set.
- R4: A zero-byte transaction yields exactly one fragment with `frag_bytes` = 0 and both markers set.
- R5: While `frag_valid` is 1 and `frag_accept` is 0, `frag_valid` stays 1 and every fragment field stays unchanged.
- R6: In the cycle after a fragment is accepted, `frag_valid` is 0.
- R7: Between an accepted fragment and the next fragment of the same transaction, `frag_valid` is low for exactly 1 + max(1, ceil(bytes/BYTES_PER_CYCLE)) cycles, where bytes is the next fragment's size and the default BYTES_PER_CYCLE is 8.
- R8: Every fragment carries the source ID, destination ID and tag of its transaction.
- R9: With SRC_FLOW_CTRL = 1, `txn_ready` is 0 while a fragment is being offered. `txn_done` is a single-cycle pulse in the cycle after the last fragment is accepted, and it is never high in two consecutive cycles.
- R10: With SRC_FLOW_CTRL = 0, `txn_ready` is 1 while the current transaction is still being cut, so a second transaction can be handed over early. That transaction's fragments follow directly after the first one's, and `txn_done` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txn_valid | input | 1 | Source offers a transaction descriptor |
| txn_ready | output | 1 | Block takes the descriptor at this edge |
| txn_bytes | input | 16 | Transaction byte count |
| txn_src | input | 8 | Source ID |
| txn_dst | input | 8 | Destination ID |
| txn_tag | input | 6 | Transaction tag |
| frag_valid | output | 1 | A fragment descriptor is offered |
| frag_accept | input | 1 | Queue accepts the offered fragment |
| frag_bytes | output | 9 | Payload bytes in this fragment |
| frag_first | output | 1 | First fragment of its transaction |
| frag_last | output | 1 | Final fragment of its transaction |
| frag_src | output | 8 | Copied source ID |
| frag_dst | output | 8 | Copied destination ID |
| frag_tag | output | 6 | Copied tag |
| txn_done | output | 1 | All fragments of a transaction accepted (flow-control mode only) |

## Verification
The hardest condition to create from the ports is a handover while work is in flight: a second transaction accepted before the first has finished fragmenting. The bench reaches it with a second instance that has source flow control turned off. It waits until that instance's first fragment appears, then pushes a short transaction. The bench then checks that the fragment order runs straight from the remainder of the first transaction into the second one, with its first marker set. On the main instance, accepts are deliberately held back for several cycles on a middle fragment to show that the offer stays frozen. The bench also counts the idle cycles between fragments so that the gap and the size-dependent generation delay are measured separately.

// File: rtl/frag_pkg.sv
package frag_pkg;

    localparam int LEN_W = 16;
    localparam int ID_W  = 8;
    localparam int TAG_W = 6;

    typedef struct packed {
        logic [LEN_W-1:0] bytes;
        logic [ID_W-1:0]  src;
        logic [ID_W-1:0]  dst;
        logic [TAG_W-1:0] tag;
    } txn_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_GEN,
        ST_OFFER,
        ST_GAP
    } frag_state_e;

endpackage

// File: rtl/frag_intake.sv
module frag_intake
    import frag_pkg::*;
#(
    parameter bit SRC_FLOW_CTRL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic txn_valid,
    input  txn_t txn_in,
    output logic txn_ready,
    input  logic seq_idle,
    input  logic take,
    output logic held_v,
    output txn_t held
);

    // With flow control the source may hand over only while nothing is in flight.
    generate
        if (SRC_FLOW_CTRL) begin : g_gated
            assign txn_ready = !held_v && seq_idle;
        end else begin : g_free
            assign txn_ready = !held_v;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            held_v <= 1'b0;
            held   <= '0;
        end else if (txn_valid && txn_ready) begin
            held_v <= 1'b1;
            held   <= txn_in;
        end else if (take) begin
            held_v <= 1'b0;
        end
    end

endmodule

// File: rtl/frag_sizer.sv
module frag_sizer
    import frag_pkg::*;
#(
    parameter int MAX_PAYLOAD     = 256,
    parameter int BYTES_PER_CYCLE = 8,
    localparam int FRAG_W = $clog2(MAX_PAYLOAD + 1),
    localparam int GEN_W  = $clog2(MAX_PAYLOAD / BYTES_PER_CYCLE + 2)
) (
    input  logic [LEN_W-1:0]  remaining,
    output logic [FRAG_W-1:0] cur_bytes,
    output logic              is_last,
    output logic [GEN_W-1:0]  gen_len
);

    localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_PAYLOAD);

    logic [FRAG_W:0] rounded;
    logic [FRAG_W:0] quot;

    always_comb begin
        is_last   = (remaining <= MAX_L);
        cur_bytes = is_last ? remaining[FRAG_W-1:0] : FRAG_W'(MAX_PAYLOAD);
        rounded   = {1'b0, cur_bytes} + (FRAG_W+1)'(BYTES_PER_CYCLE - 1);
        quot      = rounded / (FRAG_W+1)'(BYTES_PER_CYCLE);
        // A header-only fragment still costs one generation cycle.
        gen_len   = (quot == '0) ? GEN_W'(1) : GEN_W'(quot);
    end

endmodule

// File: rtl/frag_seq.sv
module frag_seq
    import frag_pkg::*;
#(
    parameter int MAX_PAYLOAD     = 256,
    parameter int BYTES_PER_CYCLE = 8,
    parameter bit SRC_FLOW_CTRL   = 1'b1,
    localparam int FRAG_W = $clog2(MAX_PAYLOAD + 1),
    localparam int GEN_W  = $clog2(MAX_PAYLOAD / BYTES_PER_CYCLE + 2)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              held_v,
    input  txn_t              held,
    output logic              seq_idle,
    output logic              take,
    output logic              frag_valid,
    input  logic              frag_accept,
    output logic [FRAG_W-1:0] frag_bytes,
    output logic              frag_first,
    output logic              frag_last,
    output logic [ID_W-1:0]   frag_src,
    output logic [ID_W-1:0]   frag_dst,
    output logic [TAG_W-1:0]  frag_tag,
    output logic              txn_done
);

    frag_state_e       state;
    logic [LEN_W-1:0]  rem;
    logic              first_q;
    logic [GEN_W-1:0]  gen_cnt;
    txn_t              meta;
    logic              done_q;

    logic [LEN_W-1:0]  size_in;
    logic [FRAG_W-1:0] cur_bytes;
    logic              is_last;
    logic [GEN_W-1:0]  gen_len;

    // In idle the sizer looks ahead at the staged transaction.
    assign size_in = (state == ST_IDLE) ? held.bytes : rem;

    frag_sizer #(
        .MAX_PAYLOAD    (MAX_PAYLOAD),
        .BYTES_PER_CYCLE(BYTES_PER_CYCLE)
    ) u_sizer (
        .remaining(size_in),
        .cur_bytes(cur_bytes),
        .is_last  (is_last),
        .gen_len  (gen_len)
    );

    assign seq_idle = (state == ST_IDLE);
    assign take     = seq_idle && held_v;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            rem     <= '0;
            first_q <= 1'b0;
            gen_cnt <= '0;
            meta    <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (held_v) begin
                        rem     <= held.bytes;
                        meta    <= held;
                        first_q <= 1'b1;
                        gen_cnt <= gen_len;
                        state   <= ST_GEN;
                    end
                end
                ST_GEN: begin
                    if (gen_cnt <= GEN_W'(1)) begin
                        state <= ST_OFFER;
                    end else begin
                        gen_cnt <= gen_cnt - GEN_W'(1);
                    end
                end
                ST_OFFER: begin
                    if (frag_accept) begin
                        rem     <= rem - LEN_W'(cur_bytes);
                        first_q <= 1'b0;
                        if (is_last) begin
                            state  <= ST_IDLE;
                            done_q <= SRC_FLOW_CTRL;
                        end else begin
                            state <= ST_GAP;
                        end
                    end
                end
                ST_GAP: begin
                    gen_cnt <= gen_len;
                    state   <= ST_GEN;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign frag_valid = (state == ST_OFFER);
    assign frag_bytes = cur_bytes;
    assign frag_first = first_q;
    assign frag_last  = is_last;
    assign frag_src   = meta.src;
    assign frag_dst   = meta.dst;
    assign frag_tag   = meta.tag;
    assign txn_done   = done_q;

endmodule

// File: rtl/txn_fragmenter.sv
module txn_fragmenter
    import frag_pkg::*;
#(
    parameter int MAX_PAYLOAD     = 256,
    parameter int BYTES_PER_CYCLE = 8,
    parameter bit SRC_FLOW_CTRL   = 1'b1
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               txn_valid,
    output logic                               txn_ready,
    input  logic [15:0]                        txn_bytes,
    input  logic [7:0]                         txn_src,
    input  logic [7:0]                         txn_dst,
    input  logic [5:0]                         txn_tag,
    output logic                               frag_valid,
    input  logic                               frag_accept,
    output logic [$clog2(MAX_PAYLOAD+1)-1:0]   frag_bytes,
    output logic                               frag_first,
    output logic                               frag_last,
    output logic [7:0]                         frag_src,
    output logic [7:0]                         frag_dst,
    output logic [5:0]                         frag_tag,
    output logic                               txn_done
);

    txn_t txn_in;
    txn_t held;
    logic held_v;
    logic seq_idle;
    logic take;

    assign txn_in = '{bytes: txn_bytes, src: txn_src, dst: txn_dst, tag: txn_tag};

    frag_intake #(
        .SRC_FLOW_CTRL(SRC_FLOW_CTRL)
    ) u_intake (
        .clk      (clk),
        .rst      (rst),
        .txn_valid(txn_valid),
        .txn_in   (txn_in),
        .txn_ready(txn_ready),
        .seq_idle (seq_idle),
        .take     (take),
        .held_v   (held_v),
        .held     (held)
    );

    frag_seq #(
        .MAX_PAYLOAD    (MAX_PAYLOAD),
        .BYTES_PER_CYCLE(BYTES_PER_CYCLE),
        .SRC_FLOW_CTRL  (SRC_FLOW_CTRL)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .held_v     (held_v),
        .held       (held),
        .seq_idle   (seq_idle),
        .take       (take),
        .frag_valid (frag_valid),
        .frag_accept(frag_accept),
        .frag_bytes (frag_bytes),
        .frag_first (frag_first),
        .frag_last  (frag_last),
        .frag_src   (frag_src),
        .frag_dst   (frag_dst),
        .frag_tag   (frag_tag),
        .txn_done   (txn_done)
    );

endmodule

// File: rtl/frag_checker.sv
module frag_checker #(
    parameter int MAX_PAYLOAD   = 256,
    parameter bit SRC_FLOW_CTRL = 1'b1,
    localparam int FRAG_W = $clog2(MAX_PAYLOAD + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              txn_ready,
    input logic              frag_valid,
    input logic              frag_accept,
    input logic [FRAG_W-1:0] frag_bytes,
    input logic              frag_first,
    input logic              frag_last,
    input logic [7:0]        frag_src,
    input logic [7:0]        frag_dst,
    input logic [5:0]        frag_tag,
    input logic              txn_done
);

    assert_full_fragment_R2: assert property (@(posedge clk) disable iff (rst)
        frag_valid && !frag_last |-> frag_bytes == FRAG_W'(MAX_PAYLOAD));

    assert_bound_R2: assert property (@(posedge clk) disable iff (rst)
        frag_valid |-> frag_bytes <= FRAG_W'(MAX_PAYLOAD));

    assert_zero_single_R4: assert property (@(posedge clk) disable iff (rst)
        frag_valid && frag_first && frag_bytes == '0 |-> frag_last);

    assert_offer_held_R5: assert property (@(posedge clk) disable iff (rst)
        frag_valid && !frag_accept |=> frag_valid && $stable(frag_bytes) &&
        $stable(frag_first) && $stable(frag_last) && $stable(frag_src) &&
        $stable(frag_dst) && $stable(frag_tag));

    assert_idle_gap_R6: assert property (@(posedge clk) disable iff (rst)
        frag_valid && frag_accept |=> !frag_valid);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        txn_done |=> !txn_done);

    assert_done_cause_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(txn_done) |-> $past(frag_valid && frag_accept && frag_last));

    assert_busy_R9: assert property (@(posedge clk) disable iff (rst)
        frag_valid && SRC_FLOW_CTRL |-> !txn_ready);

endmodule

bind txn_fragmenter frag_checker #(
    .MAX_PAYLOAD  (MAX_PAYLOAD),
    .SRC_FLOW_CTRL(SRC_FLOW_CTRL)
) u_frag_checker (
    .clk        (clk),
    .rst        (rst),
    .txn_ready  (txn_ready),
    .frag_valid (frag_valid),
    .frag_accept(frag_accept),
    .frag_bytes (frag_bytes),
    .frag_first (frag_first),
    .frag_last  (frag_last),
    .frag_src   (frag_src),
    .frag_dst   (frag_dst),
    .frag_tag   (frag_tag),
    .txn_done   (txn_done)
);

// File: tb/test_txn_fragmenter.sv
module test_txn_fragmenter;

    localparam int MAXP = 256;
    localparam int BPC  = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    // main instance: source flow control on
    logic       txn_valid = 1'b0;
    logic       txn_ready;
    logic [15:0] txn_bytes = '0;
    logic [7:0] txn_src = '0, txn_dst = '0;
    logic [5:0] txn_tag = '0;
    logic       frag_valid, frag_accept = 1'b0;
    logic [8:0] frag_bytes;
    logic       frag_first, frag_last, txn_done;
    logic [7:0] frag_src, frag_dst;
    logic [5:0] frag_tag;

    // second instance: source flow control off
    logic       n_valid = 1'b0;
    logic       n_ready;
    logic [15:0] n_bytes = '0;
    logic [5:0] n_tag = '0;
    logic       n_fvalid;
    logic [8:0] n_fbytes;
    logic       n_ffirst, n_flast, n_done;
    logic [7:0] n_fsrc, n_fdst;
    logic [5:0] n_ftag;

    txn_fragmenter #(.MAX_PAYLOAD(MAXP), .BYTES_PER_CYCLE(BPC), .SRC_FLOW_CTRL(1'b1)) i_txn_fragmenter (
        .clk(clk), .rst(rst), .txn_valid(txn_valid), .txn_ready(txn_ready),
        .txn_bytes(txn_bytes), .txn_src(txn_src), .txn_dst(txn_dst), .txn_tag(txn_tag),
        .frag_valid(frag_valid), .frag_accept(frag_accept), .frag_bytes(frag_bytes),
        .frag_first(frag_first), .frag_last(frag_last), .frag_src(frag_src),
        .frag_dst(frag_dst), .frag_tag(frag_tag), .txn_done(txn_done));

    txn_fragmenter #(.MAX_PAYLOAD(MAXP), .BYTES_PER_CYCLE(BPC), .SRC_FLOW_CTRL(1'b0)) i_txn_fragmenter_nofc (
        .clk(clk), .rst(rst), .txn_valid(n_valid), .txn_ready(n_ready),
        .txn_bytes(n_bytes), .txn_src(8'h11), .txn_dst(8'h22), .txn_tag(n_tag),
        .frag_valid(n_fvalid), .frag_accept(1'b1), .frag_bytes(n_fbytes),
        .frag_first(n_ffirst), .frag_last(n_flast), .frag_src(n_fsrc),
        .frag_dst(n_fdst), .frag_tag(n_ftag), .txn_done(n_done));

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int gen_cycles(input int b);
        int c;
        c = (b + BPC - 1) / BPC;
        return (c < 1) ? 1 : c;
    endfunction

    task automatic push(input int bytes, input int src, input int dst, input int tag);
        int guard = 0;
        @(negedge clk);
        while (!txn_ready && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        txn_valid = 1'b1;
        txn_bytes = 16'(bytes);
        txn_src   = 8'(src);
        txn_dst   = 8'(dst);
        txn_tag   = 6'(tag);
        @(negedge clk);
        txn_valid = 1'b0;
    endtask

    // Collects every fragment of one transaction on the main instance.
    task automatic collect(input int bytes, input int src, input int dst, input int tag,
                           input int stall_idx);
        int rem = bytes;
        int idx = 0;
        bit last_seen = 1'b0;
        while (!last_seen) begin
            int e = (rem > MAXP) ? MAXP : rem;
            int low = 0;
            while (!frag_valid && low < 2000) begin
                low++;
                @(negedge clk);
            end
            if (idx > 0)
                chk(low == gen_cycles(e) + 1, "R7 idle cycles before fragment", low, gen_cycles(e) + 1);
            chk(int'(frag_bytes) == e, "R2 fragment size", int'(frag_bytes), e);
            chk(frag_first == (idx == 0), "R3 first marker", int'(frag_first), int'(idx == 0));
            chk(frag_last == (rem <= MAXP), "R3 last marker", int'(frag_last), int'(rem <= MAXP));
            chk(int'(frag_src) == src && int'(frag_dst) == dst && int'(frag_tag) == tag,
                "R8 ids and tag", int'({frag_src, frag_dst, frag_tag}), (src << 14) | (dst << 6) | tag);
            chk(!txn_ready, "R9 ready low while offering", int'(txn_ready), 0);
            if (idx == stall_idx) begin
                repeat (3) @(negedge clk);
                chk(frag_valid && int'(frag_bytes) == e && frag_first == (idx == 0),
                    "R5 offer frozen while not accepted", int'(frag_bytes), e);
            end
            last_seen = frag_last;
            frag_accept = 1'b1;
            @(negedge clk);
            frag_accept = 1'b0;
            chk(!frag_valid, "R6 valid low after accept", int'(frag_valid), 0);
            if (last_seen) begin
                chk(txn_done, "R9 done after last accept", int'(txn_done), 1);
                @(negedge clk);
                chk(!txn_done, "R9 done single cycle", int'(txn_done), 0);
            end else begin
                chk(!txn_done, "R9 no done mid transaction", int'(txn_done), 0);
            end
            rem = rem - e;
            idx++;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!frag_valid, "R1 frag_valid after reset", int'(frag_valid), 0);
        chk(!txn_done, "R1 txn_done after reset", int'(txn_done), 0);
        chk(txn_ready, "R1 txn_ready after reset", int'(txn_ready), 1);
    endtask

    task automatic t_exact_max();
        push(256, 3, 4, 5);
        collect(256, 3, 4, 5, -1);
    endtask

    task automatic t_multi();
        push(700, 8'hA5, 8'h5A, 6'h2B);
        collect(700, 8'hA5, 8'h5A, 6'h2B, 1);
    endtask

    task automatic t_zero();
        push(0, 1, 2, 9);
        collect(0, 1, 2, 9, 0);
    endtask

    task automatic t_small();
        push(5, 7, 6, 1);
        collect(5, 7, 6, 1, -1);
    endtask

    task automatic t_no_flow_ctrl();
        int got_b [8];
        int got_f [8];
        int cnt = 0;
        int guard = 0;
        bit done_seen = 1'b0;
        @(negedge clk);
        n_valid = 1'b1; n_bytes = 16'd600; n_tag = 6'd1;
        @(negedge clk);
        n_valid = 1'b0;
        while (!n_fvalid && guard < 500) begin
            @(negedge clk);
            guard++;
        end
        got_b[cnt] = int'(n_fbytes); got_f[cnt] = int'(n_ffirst); cnt++;
        chk(n_ready, "R10 ready while fragmenting", int'(n_ready), 1);
        n_valid = 1'b1; n_bytes = 16'd10; n_tag = 6'd2;
        @(negedge clk);
        n_valid = 1'b0;
        for (int i = 0; i < 300; i++) begin
            if (n_done) done_seen = 1'b1;
            if (n_fvalid && cnt < 8) begin
                got_b[cnt] = int'(n_fbytes); got_f[cnt] = int'(n_ffirst); cnt++;
            end
            @(negedge clk);
        end
        chk(cnt == 4, "R10 fragment count over two transactions", cnt, 4);
        chk(got_b[0] == 256 && got_b[1] == 256, "R10 leading full fragments", got_b[1], 256);
        chk(got_b[2] == 88, "R10 remainder of first transaction", got_b[2], 88);
        chk(got_b[3] == 10 && got_f[3] == 1, "R10 early transaction follows", got_b[3], 10);
        chk(!done_seen, "R10 no completion event", int'(done_seen), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_exact_max();
        t_multi();
        t_zero();
        t_small();
        t_no_flow_ctrl();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule